// File: doc/BRIEF.md
# Lamp Ignition Supervisor

This block runs the start-up and fault sequence of a phase-controlled resonant lamp ballast. Coming out of reset it holds the inverter in free-running oscillator mode for a fixed interval. It then hands the phase loop a start-up phase command that begins at the 90-degree code and walks down one code at a time, on a programmable interval, toward resonance. The walk stops when the sampled lamp current rises above a threshold. At that point closed-loop operation takes over.

While the block is not in closed loop, it asks the current compensator to track the start-up phase, so the handover produces no step in the phase command. If the walk reaches a programmable floor code and the lamp has not struck, the block drops back to oscillator mode, reloads the full-scale phase and tries again. A lamp overvoltage turns the gate enable off in the same cycle and forces oscillator mode. Restart waits until the overvoltage input has cleared and a programmable cool-down has elapsed. After that the initial oscillator interval runs again.

All intervals count ticks of an internal prescaler: `TICK_DIV` clocks per tick, which gives 1 us at 200 MHz by default. Callers would normally set the step interval to 5000 ticks. The overvoltage input is taken as already synchronous to `clk_i`.

Top module: `lamp_ign_sup`

## Requirements
- R1: While reset is asserted and directly after release, `mode_o` is oscillator (code 0), `phase_st_o` is 511, `comp_track_o` is 1 and `gate_en_o` is 1 when `ovp_i` is low.
- R2: After reset release, `mode_o` changes to sweep (code 1) on the clock edge OSC_TICKS*TICK_DIV+1, and `phase_st_o` is 511 at that point.
- R3: In sweep mode `phase_st_o` decreases by exactly 1 once every `step_ticks_i`*TICK_DIV+1 clock cycles, starting from sweep entry.
- R4: In sweep mode, when `lamp_cur_i` is strictly greater than `cur_thr_i`, `mode_o` becomes closed loop (code 2) on the next edge and `phase_st_o` keeps its value. A current equal to the threshold does not end the sweep. Closed loop is entered only from sweep.
- R5: A lamp current above the threshold has no effect in oscillator mode, during a fault or during cool-down.
- R6: When a step interval ends while `phase_st_o` <= `phase_low_i`, `mode_o` returns to oscillator and `phase_st_o` to 511, and a new sweep starts after a full oscillator interval.
- R7: `comp_track_o` is 1 in every mode except closed loop, and 0 in closed loop.
- R8: When `ovp_i` is high, `gate_en_o` is 0 in the same cycle. From the next edge `mode_o` is oscillator and `phase_st_o` is 511, and this overrides every other transition, ignition included.
- R9: After `ovp_i` falls, `gate_en_o` stays 0 until `cool_ticks_i`*TICK_DIV+2 edges have passed. An overvoltage during cool-down restarts the lockout. When the gates come back, the oscillator interval of R2 runs again before sweeping.
- R10: Closed-loop mode and its phase value persist until an overvoltage occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lamp_cur_i | input | CUR_W | Sampled peak lamp current |
| cur_thr_i | input | CUR_W | Ignition current threshold |
| ovp_i | input | 1 | Lamp overvoltage comparator, synchronous |
| step_ticks_i | input | CNT_W | Sweep step interval in ticks |
| cool_ticks_i | input | CNT_W | Cool-down hold-off in ticks |
| phase_low_i | input | PH_W | Sweep floor code |
| mode_o | output | 2 | 0 oscillator, 1 sweep, 2 closed loop |
| phase_st_o | output | PH_W | Start-up phase command, 511 = 90 degrees |
| comp_track_o | output | 1 | Compensator tracks start-up phase |
| gate_en_o | output | 1 | Gate driver enable |

## Verification
The bench measures every interval edge-exactly: the initial oscillator hold, each sweep step and the cool-down. A timer that restarted one cycle late, or ignored the prescaler, would show up as a miscounted step period or a misplaced return of the gates. It drives a current equal to the threshold, which a non-strict comparator would accept as ignition. It checks that a high current in oscillator mode or cool-down starts nothing. It raises overvoltage in the same cycle as ignition, where a design with the wrong priority would enter closed loop. It also re-raises overvoltage during cool-down, which a lockout that is not restarted would let through. A floor-limited sweep checks that the block falls back to oscillator mode after exactly one dwell at the floor code, and does not stop early or wrap the phase below zero.

// File: rtl/ign_pkg.sv
package ign_pkg;
  typedef enum logic [2:0] {
    ST_OSC, ST_SWEEP, ST_RUN, ST_FAULT, ST_COOL
  } ign_state_e;

  typedef enum logic [1:0] {
    MODE_OSC    = 2'd0,
    MODE_SWEEP  = 2'd1,
    MODE_CLOSED = 2'd2
  } ign_mode_e;
endpackage

// File: rtl/ign_timer.sv
// Interval timer with its own prescaler; restart clears both stages.
module ign_timer #(
  parameter int TICK_DIV = 200,
  parameter int CNT_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             elapsed_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic             tick;
  logic [CNT_W-1:0] cnt_q;

  if (TICK_DIV > 1) begin : g_pre
    logic [PRE_W-1:0] pre_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             pre_q <= '0;
      else if (restart_i)                      pre_q <= '0;
      else if (pre_q == PRE_W'(TICK_DIV - 1))  pre_q <= '0;
      else                                     pre_q <= pre_q + 1'b1;
    end
    assign tick = !restart_i && (pre_q == PRE_W'(TICK_DIV - 1));
  end else begin : g_nopre
    assign tick = !restart_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (restart_i)            cnt_q <= '0;
    else if (tick && cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
  end

  assign elapsed_o = (cnt_q >= target_i);
endmodule

// File: rtl/ign_phase_gen.sv
// Start-up phase register: full-scale load, single-code decrement.
module ign_phase_gen #(
  parameter int PH_W = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_full_i,
  input  logic            step_i,
  input  logic [PH_W-1:0] low_i,
  output logic [PH_W-1:0] phase_o,
  output logic            at_floor_o
);
  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       phase_q <= '1;
    else if (load_full_i)              phase_q <= '1;
    else if (step_i && phase_q != '0)  phase_q <= phase_q - 1'b1;
  end

  assign phase_o    = phase_q;
  assign at_floor_o = (phase_q <= low_i);
endmodule

// File: rtl/ign_seq.sv
// Sequencer; overvoltage pre-empts every other transition.
module ign_seq
  import ign_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ovp_i,
  input  logic       ignite_i,
  input  logic       elapsed_i,
  input  logic       at_floor_i,
  output ign_state_e state_o,
  output logic       restart_o,
  output logic       load_full_o,
  output logic       step_o
);
  ign_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    restart_o   = 1'b0;
    load_full_o = 1'b0;
    step_o      = 1'b0;
    if (ovp_i) begin
      state_d     = ST_FAULT;
      restart_o   = 1'b1;
      load_full_o = 1'b1;
    end else begin
      unique case (state_q)
        ST_OSC: if (elapsed_i) begin
          state_d     = ST_SWEEP;
          restart_o   = 1'b1;
          load_full_o = 1'b1;
        end
        ST_SWEEP: begin
          if (ignite_i) begin
            state_d = ST_RUN;
          end else if (elapsed_i) begin
            restart_o = 1'b1;
            if (at_floor_i) begin
              state_d     = ST_OSC;
              load_full_o = 1'b1;
            end else begin
              step_o = 1'b1;
            end
          end
        end
        ST_RUN: state_d = ST_RUN;
        ST_FAULT: begin
          state_d   = ST_COOL;
          restart_o = 1'b1;
        end
        ST_COOL: if (elapsed_i) begin
          state_d     = ST_OSC;
          restart_o   = 1'b1;
          load_full_o = 1'b1;
        end
        default: begin
          state_d     = ST_FAULT;
          load_full_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OSC;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/lamp_ign_sup.sv
module lamp_ign_sup
  import ign_pkg::*;
#(
  parameter int PH_W      = 9,
  parameter int CUR_W     = 8,
  parameter int CNT_W     = 16,
  parameter int TICK_DIV  = 200,
  parameter int OSC_TICKS = 10000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CUR_W-1:0] lamp_cur_i,
  input  logic [CUR_W-1:0] cur_thr_i,
  input  logic             ovp_i,
  input  logic [CNT_W-1:0] step_ticks_i,
  input  logic [CNT_W-1:0] cool_ticks_i,
  input  logic [PH_W-1:0]  phase_low_i,
  output logic [1:0]       mode_o,
  output logic [PH_W-1:0]  phase_st_o,
  output logic             comp_track_o,
  output logic             gate_en_o
);
  localparam logic [CNT_W-1:0] OSC_TGT = CNT_W'(OSC_TICKS);

  ign_state_e       state;
  logic             restart, load_full, step, elapsed, at_floor, ignite;
  logic [CNT_W-1:0] target;

  assign ignite = (lamp_cur_i > cur_thr_i);

  always_comb begin
    unique case (state)
      ST_OSC:   target = OSC_TGT;
      ST_SWEEP: target = step_ticks_i;
      ST_COOL:  target = cool_ticks_i;
      default:  target = '0;
    endcase
  end

  ign_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ovp_i       (ovp_i),
    .ignite_i    (ignite),
    .elapsed_i   (elapsed),
    .at_floor_i  (at_floor),
    .state_o     (state),
    .restart_o   (restart),
    .load_full_o (load_full),
    .step_o      (step)
  );

  ign_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .target_i  (target),
    .elapsed_o (elapsed)
  );

  ign_phase_gen #(.PH_W(PH_W)) i_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_full_i (load_full),
    .step_i      (step),
    .low_i       (phase_low_i),
    .phase_o     (phase_st_o),
    .at_floor_o  (at_floor)
  );

  always_comb begin
    unique case (state)
      ST_SWEEP: mode_o = MODE_SWEEP;
      ST_RUN:   mode_o = MODE_CLOSED;
      default:  mode_o = MODE_OSC;
    endcase
  end

  assign comp_track_o = (state != ST_RUN);
  // gate cut is combinational so an overvoltage acts in its own cycle
  assign gate_en_o = !ovp_i && (state != ST_FAULT) && (state != ST_COOL);
endmodule

// File: rtl/ign_sup_checker.sv
module ign_sup_checker
  import ign_pkg::*;
#(
  parameter int PH_W  = 9,
  parameter int CUR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ovp_i,
  input logic [CUR_W-1:0] lamp_cur_i,
  input logic [CUR_W-1:0] cur_thr_i,
  input logic [1:0]       mode_o,
  input logic [PH_W-1:0]  phase_st_o,
  input logic             comp_track_o,
  input logic             gate_en_o
);
  AST_GATE_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovp_i |-> !gate_en_o); // R8
  AST_OVP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovp_i |=> (mode_o == MODE_OSC && phase_st_o == '1)); // R8
  AST_OSC_FULL_SCALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_OSC) |-> (phase_st_o == '1)); // R6
  AST_PHASE_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_SWEEP && $past(mode_o) == MODE_SWEEP)
      |-> (phase_st_o == $past(phase_st_o) || (phase_st_o + 1'b1) == $past(phase_st_o))); // R3
  AST_IGNITE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_SWEEP && lamp_cur_i > cur_thr_i && !ovp_i)
      |=> (mode_o == MODE_CLOSED && $stable(phase_st_o))); // R4
  AST_CLOSED_FROM_SWEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_CLOSED && $past(mode_o) != MODE_CLOSED)
      |-> ($past(mode_o) == MODE_SWEEP)); // R4
  AST_CLOSED_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_CLOSED && !ovp_i) |=> (mode_o == MODE_CLOSED && $stable(phase_st_o))); // R10
  AST_TRACK_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_track_o == (mode_o != MODE_CLOSED)); // R7
  AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3); // R1
endmodule

bind lamp_ign_sup ign_sup_checker #(.PH_W(PH_W), .CUR_W(CUR_W)) i_ign_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ovp_i        (ovp_i),
  .lamp_cur_i   (lamp_cur_i),
  .cur_thr_i    (cur_thr_i),
  .mode_o       (mode_o),
  .phase_st_o   (phase_st_o),
  .comp_track_o (comp_track_o),
  .gate_en_o    (gate_en_o)
);

// File: tb/test_lamp_ign_sup.sv
module test_lamp_ign_sup;
  localparam int P     = 4;
  localparam int OSC_N = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] lamp_cur_i = '0;
  logic [7:0] cur_thr_i = 8'd100;
  logic       ovp_i = 1'b0;
  logic [15:0] step_ticks_i = 16'd2;
  logic [15:0] cool_ticks_i = 16'd3;
  logic [8:0] phase_low_i = 9'd4;
  logic [1:0] mode_o;
  logic [8:0] phase_st_o;
  logic       comp_track_o, gate_en_o;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  lamp_ign_sup #(.TICK_DIV(P), .OSC_TICKS(OSC_N)) i_lamp_ign_sup (.*);

  function automatic int intv(input int ticks);
    return ticks * P + 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge1;
    @(posedge clk_i); #1;
  endtask

  task automatic wait_mode(input int m, input int lim, output int n);
    n = 0;
    do begin edge1(); n++; end while (int'(mode_o) != m && n <= lim);
  endtask

  task automatic wait_step(output int n);
    logic [8:0] old;
    old = phase_st_o;
    n = 0;
    do begin edge1(); n++; end while (phase_st_o == old && n < 5000);
  endtask

  task automatic wait_gate(output int n);
    n = 0;
    do begin edge1(); n++; end while (!gate_en_o && n < 5000);
  endtask

  // Raise overvoltage (optionally with a current above threshold), drop it, check lockout.
  task automatic fault_cycle(input int hold, input int cool);
    int n;
    ovp_i = 1'b1; #1;
    chk("R8 gate cut same cycle", gate_en_o, 0);
    edge1();
    chk("R8 mode osc after ovp", mode_o, 0);
    chk("R8 phase full after ovp", phase_st_o, 511);
    lamp_cur_i = 8'hff;
    for (int i = 0; i < hold; i++) edge1();
    chk("R5 no ignition during fault", mode_o, 0);
    chk("R9 gate off while ovp high", gate_en_o, 0);
    cool_ticks_i = 16'(cool);
    ovp_i = 1'b0;
    wait_gate(n);
    chk("R9 cool-down length", n, cool * P + 2);
    chk("R5 no ignition in cool-down", mode_o, 0);
    lamp_cur_i = '0;
  endtask

  initial begin
    int n;
    int seed;
    int exp_ph;
    seed = $urandom(32'd1234);
    // R1 reset state
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset mode", mode_o, 0);
    chk("R1 reset phase", phase_st_o, 511);
    chk("R1 reset track", comp_track_o, 1);
    chk("R1 reset gate", gate_en_o, 1);
    lamp_cur_i = 8'd200;
    rst_ni = 1'b1;
    // R2 oscillator hold, with R5 current ignored in osc mode
    n = 0;
    while (int'(mode_o) != 1 && n < 1000) begin
      edge1(); n++;
      if (n == 40) begin
        chk("R5 high current ignored in osc", mode_o, 0);
        lamp_cur_i = 8'd0;
      end
    end
    chk("R2 osc interval", n, OSC_N * P + 1);
    chk("R2 phase at sweep entry", phase_st_o, 511);
    chk("R7 track in sweep", comp_track_o, 1);
    // R3 step timing
    for (int i = 1; i <= 3; i++) begin
      wait_step(n);
      chk("R3 step interval", n, intv(2));
      chk("R3 step value", phase_st_o, 511 - i);
    end
    // R4 threshold is strict
    lamp_cur_i = cur_thr_i;
    edge1(); edge1();
    chk("R4 equal current no ignition", mode_o, 1);
    exp_ph = phase_st_o;
    lamp_cur_i = cur_thr_i + 8'd1;
    edge1();
    chk("R4 ignite next edge", mode_o, 2);
    chk("R4 phase held at ignition", phase_st_o, exp_ph);
    chk("R7 track off in closed loop", comp_track_o, 0);
    lamp_cur_i = '0;
    for (int i = 0; i < 60; i++) edge1();
    chk("R10 closed loop persists", mode_o, 2);
    chk("R10 phase stable", phase_st_o, exp_ph);
    // R8/R9 overvoltage, re-fault during cool-down
    ovp_i = 1'b1; #1;
    chk("R8 gate cut in closed loop", gate_en_o, 0);
    edge1();
    chk("R8 leaves closed loop", mode_o, 0);
    chk("R7 track after fault", comp_track_o, 1);
    repeat (5) edge1();
    ovp_i = 1'b0;
    repeat (6) edge1();
    chk("R9 gate off in cool-down", gate_en_o, 0);
    ovp_i = 1'b1;
    edge1(); edge1();
    ovp_i = 1'b0;
    wait_gate(n);
    chk("R9 re-fault restarts cool-down", n, 3 * P + 2);
    wait_mode(1, 1000, n);
    chk("R9 osc interval after cool-down", n, OSC_N * P + 1);
    // R6 floor reached -> retry
    phase_low_i = 9'd505;
    wait_mode(0, 1000, n);
    chk("R6 fall back after floor dwell", n, 7 * intv(2));
    chk("R6 phase reloaded", phase_st_o, 511);
    wait_mode(1, 1000, n);
    chk("R6 retry after osc interval", n, OSC_N * P + 1);
    // R8 priority over ignition in the same cycle
    lamp_cur_i = 8'd250;
    ovp_i = 1'b1;
    edge1();
    chk("R8 ovp beats ignition", mode_o, 0);
    ovp_i = 1'b0;
    lamp_cur_i = '0;
    wait_gate(n);
    chk("R9 cool-down after priority case", n, 3 * P + 2);
    // constrained random trials
    for (int t = 0; t < 12; t++) begin
      int st, lw, k, cl;
      st = $urandom_range(0, 3);
      lw = $urandom_range(490, 509);
      cl = $urandom_range(0, 3);
      k  = $urandom_range(0, 511 - lw);
      step_ticks_i = 16'(st);
      phase_low_i  = 9'(lw);
      cur_thr_i    = 8'($urandom_range(0, 200));
      fault_cycle($urandom_range(1, 4), cl);
      wait_mode(1, 1000, n);
      chk("R2 random osc interval", n, OSC_N * P + 1);
      for (int i = 1; i <= k; i++) begin
        wait_step(n);
        chk("R3 random step interval", n, intv(st));
        chk("R3 random step value", phase_st_o, 511 - i);
      end
      lamp_cur_i = cur_thr_i + 8'(1 + $urandom_range(0, 40));
      edge1();
      chk("R4 random ignition", mode_o, 2);
      chk("R4 random held phase", phase_st_o, 511 - k);
      lamp_cur_i = '0;
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule